// File: doc/BRIEF.md
# Trace Trigger and Qualifier Unit

This block sits beside a processor core and decides which core cycles are written into a trace store. It evaluates three programmable conditions every cycle: a start condition (trigger), a per-cycle filter (qualifier) and an end condition (stop). Each condition is built from the same sources: one chosen bit of an 11-bit watchpoint vector, a breakpoint line, and a masked view of a 4-bit load/store status. The selected sources are combined with either AND or OR.

When the trigger is met, it is held from then on. When a cycle is both triggered and qualified, the block issues one write per sample type chosen in the record mask. It issues them lowest type first, one per clock, and tags each write with its type. While more writes for that cycle remain, it holds a stall request towards the core. The trace memory and its readout are outside this block.

Every condition select word has the same fields. Bits [3:0] are the load/store mask and bits [7:4] are the watchpoint index. Bit 8 enables the watchpoint term, bit 9 enables the breakpoint term and bit 10 enables the load/store term. Bit 11 chooses AND (1) or OR (0). Under AND, the load/store term needs every masked status bit set. Under OR, it needs any masked bit set. Record-mask bit k selects sample type k: 0 is program counter, 1 is load/store address, 2 is store data and 3 is load data. The write tag carries that k.

Top module: `trace_gate`

## Requirements
- R1: While reset is asserted, no write and no stall are issued. Reset clears the held trigger and any unfinished sample sequence.
- R2: With the enable input low, no write and no stall are issued. Dropping enable abandons any unfinished sample sequence.
- R3: A trigger select and a qualifier select of all zeros are always met. With record mask 0001, every enabled cycle then writes tag 0.
- R4: The trigger is met when its enabled terms combine true under its operator. For example, select 0xD45 needs watchpoint 4 and status bits 0 and 2 together, and select 0x608 needs the breakpoint or status bit 3.
- R5: Once the trigger is met, later cycles stay triggered even after its sources fall.
- R6: The held trigger is cleared when enable goes low or when the stop condition is met. A cycle in which stop is met writes nothing. A stop select with no term enabled never stops.
- R7: A triggered cycle writes only if the qualifier is met. For example, qualifier select 0x200 passes exactly the cycles with the breakpoint high.
- R8: A qualified cycle produces one write per set record-mask bit, one per clock, in ascending bit order. Each write is tagged with its bit index.
- R9: The stall output is high on every write of a sequence except the last, and low otherwise.
- R10: Qualified cycles that arrive while a sequence is still draining start no new sequence.
- R11: A watchpoint index above 10 never matches.
- R12: A record mask of zero produces no write and no stall, even in qualified cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| traceEn | input | 1 | Tracing enable |
| trigSel | input | 12 | Trigger condition select |
| qualSel | input | 12 | Qualifier condition select |
| stopSel | input | 12 | Stop condition select |
| recSel | input | 4 | Record mask of sample types |
| watchpoint | input | 11 | Watchpoint hit vector |
| breakpoint | input | 1 | Breakpoint line |
| lsStatus | input | 4 | Load/store status |
| wrEn | output | 1 | Trace write strobe |
| wrType | output | 2 | Sample type tag of the current write |
| stallReq | output | 1 | Stall request towards the core |

## Verification
Two pairs of functions can coincide in one cycle: the trigger and the stop condition, and sequence draining and a fresh qualified cycle. The first pair is provoked by keeping the trigger held while the stop watchpoint rises. The expected result is no write in that cycle and no write afterwards until the trigger fires again. The second pair is provoked by holding the breakpoint qualifier high across a multi-type sequence. The expected result is that the tag order continues 0, 2, 3 unbroken, and a new sequence starts only in the cycle after stall falls.

// File: rtl/tgate_pkg.sv
package tgate_pkg;
  parameter int WP_N  = 11;
  parameter int LS_N  = 4;
  parameter int REC_N = 4;
  localparam int IDX_W = $clog2(WP_N);
  localparam int TAG_W = $clog2(REC_N);
  localparam int SEL_W = LS_N + IDX_W + 4;

  typedef struct packed {
    logic             opAnd;
    logic             lsValid;
    logic             bpValid;
    logic             wpValid;
    logic [IDX_W-1:0] wpIdx;
    logic [LS_N-1:0]  lsMask;
  } sel_t;

  typedef struct packed {
    logic setTrig;
    logic clrTrig;
    logic capture;
    logic drain;
    logic flush;
  } strobe_t;

  function automatic logic [REC_N-1:0] lowBit(input logic [REC_N-1:0] x);
    return x & (~x + 1'b1);
  endfunction

  function automatic logic [TAG_W-1:0] lowIdx(input logic [REC_N-1:0] x);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int i = REC_N - 1; i >= 0; i--)
      if (x[i]) r = TAG_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/tg_cond.sv
module tg_cond
  import tgate_pkg::*;
#(
  parameter bit ALWAYS_IF_EMPTY = 1'b1
) (
  input  sel_t            sel,
  input  logic [WP_N-1:0] wp,
  input  logic            bp,
  input  logic [LS_N-1:0] ls,
  output logic            met
);
  logic anyValid, wpHit, lsHit;
  logic [LS_N-1:0] lsSeen;

  always_comb begin
    anyValid = sel.wpValid | sel.bpValid | sel.lsValid;
    wpHit    = (int'(sel.wpIdx) < WP_N) ? wp[sel.wpIdx] : 1'b0;
    lsSeen   = ls & sel.lsMask;
    lsHit    = sel.opAnd ? (lsSeen == sel.lsMask) : (|lsSeen);
    if (!anyValid)
      met = ALWAYS_IF_EMPTY;
    else if (sel.opAnd)
      met = (!sel.wpValid | wpHit) & (!sel.bpValid | bp) & (!sel.lsValid | lsHit);
    else
      met = (sel.wpValid & wpHit) | (sel.bpValid & bp) | (sel.lsValid & lsHit);
  end
endmodule

// File: rtl/tg_datapath.sv
module tg_datapath
  import tgate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  sel_t             trigSel,
  input  sel_t             qualSel,
  input  sel_t             stopSel,
  input  logic [REC_N-1:0] recSel,
  input  logic [WP_N-1:0]  wp,
  input  logic             bp,
  input  logic [LS_N-1:0]  ls,
  input  strobe_t          ctl,
  output logic             trigMet,
  output logic             qualMet,
  output logic             stopHit,
  output logic             trigLatched,
  output logic             busy,
  output logic             recAny,
  output logic             wrEn,
  output logic [TAG_W-1:0] wrType,
  output logic             stallReq
);
  sel_t sels [3];
  logic [2:0] met;
  logic [REC_N-1:0] pending, src, rest;

  assign sels[0] = trigSel;
  assign sels[1] = qualSel;
  assign sels[2] = stopSel;

  generate
    for (genvar g = 0; g < 3; g++) begin : gCond
      tg_cond #(.ALWAYS_IF_EMPTY(g != 2)) uCond (
        .sel(sels[g]), .wp(wp), .bp(bp), .ls(ls), .met(met[g])
      );
    end
  endgenerate

  assign trigMet = met[0];
  assign qualMet = met[1];
  assign stopHit = met[2];

  always_comb begin
    src      = ctl.drain ? pending : recSel;
    rest     = src & ~lowBit(src);
    wrEn     = ctl.capture | ctl.drain;
    wrType   = lowIdx(src);
    stallReq = wrEn & (|rest);
    busy     = |pending;
    recAny   = |recSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigLatched <= 1'b0;
      pending     <= '0;
    end else begin
      if (ctl.clrTrig)      trigLatched <= 1'b0;
      else if (ctl.setTrig) trigLatched <= 1'b1;
      if (ctl.flush)                    pending <= '0;
      else if (ctl.capture | ctl.drain) pending <= rest;
    end
  end

  AST_STALL_LEAVES_WORK: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |=> busy || ctl.flush); // R9
  AST_DRAIN_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && stallReq |=> ctl.flush || (wrEn && wrType > $past(wrType))); // R8
  AST_PENDING_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    busy && !ctl.flush |=> $countones(pending) < $countones($past(pending))); // R10
endmodule

// File: rtl/tg_control.sv
module tg_control
  import tgate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    traceEn,
  input  logic    trigMet,
  input  logic    qualMet,
  input  logic    stopHit,
  input  logic    trigLatched,
  input  logic    busy,
  input  logic    recAny,
  output strobe_t ctl
);
  logic run, active;

  always_comb begin
    run         = rstN & traceEn;
    active      = run & (trigLatched | trigMet) & !stopHit;
    ctl.setTrig = run & trigMet & !stopHit;
    ctl.clrTrig = !traceEn | stopHit;
    ctl.flush   = !traceEn;
    ctl.drain   = run & busy;
    ctl.capture = active & qualMet & !busy & recAny;
  end

  AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    trigLatched && traceEn && !stopHit |=> trigLatched); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !traceEn |=> !trigLatched && !busy); // R6
  AST_STOP_BLOCKS_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    stopHit && !busy |-> !ctl.capture); // R6
endmodule

// File: rtl/trace_gate.sv
module trace_gate
  import tgate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             traceEn,
  input  logic [SEL_W-1:0] trigSel,
  input  logic [SEL_W-1:0] qualSel,
  input  logic [SEL_W-1:0] stopSel,
  input  logic [REC_N-1:0] recSel,
  input  logic [WP_N-1:0]  watchpoint,
  input  logic             breakpoint,
  input  logic [LS_N-1:0]  lsStatus,
  output logic             wrEn,
  output logic [TAG_W-1:0] wrType,
  output logic             stallReq
);
  strobe_t ctl;
  logic trigMet, qualMet, stopHit, trigLatched, busy, recAny;

  tg_control uCtl (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .trigMet(trigMet),
    .qualMet(qualMet), .stopHit(stopHit), .trigLatched(trigLatched),
    .busy(busy), .recAny(recAny), .ctl(ctl)
  );

  tg_datapath uDp (
    .clk(clk), .rstN(rstN),
    .trigSel(sel_t'(trigSel)), .qualSel(sel_t'(qualSel)), .stopSel(sel_t'(stopSel)),
    .recSel(recSel), .wp(watchpoint), .bp(breakpoint), .ls(lsStatus), .ctl(ctl),
    .trigMet(trigMet), .qualMet(qualMet), .stopHit(stopHit),
    .trigLatched(trigLatched), .busy(busy), .recAny(recAny),
    .wrEn(wrEn), .wrType(wrType), .stallReq(stallReq)
  );

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !traceEn |-> !wrEn && !stallReq); // R2
endmodule

// File: tb/tb_trace_gate.sv
module tb_trace_gate;
  import tgate_pkg::*;

  typedef struct packed {
    logic        en;
    logic [11:0] trig;
    logic [11:0] qual;
    logic [11:0] stop;
    logic [3:0]  rec;
    logic [10:0] wp;
    logic        bp;
    logic [3:0]  ls;
    logic        xWr;
    logic [1:0]  xType;
    logic        xStall;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 12'h000, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0, 1'b1, 2'd0, 1'b0, 4'd3},  // R3
    '{1'b1, 12'h000, 12'h000, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0, 1'b1, 2'd0, 1'b0, 4'd3},  // R3
    '{1'b1, 12'h000, 12'h000, 12'h000, 4'h0, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd12}, // R12
    '{1'b0, 12'h000, 12'h000, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd2},  // R2
    '{1'b1, 12'hD45, 12'h000, 12'h000, 4'h1, 11'h010, 1'b0, 4'h1, 1'b0, 2'd0, 1'b0, 4'd4},  // R4
    '{1'b1, 12'hD45, 12'h000, 12'h000, 4'h1, 11'h000, 1'b0, 4'h5, 1'b0, 2'd0, 1'b0, 4'd4},  // R4
    '{1'b1, 12'hD45, 12'h000, 12'h000, 4'h1, 11'h010, 1'b0, 4'h5, 1'b1, 2'd0, 1'b0, 4'd4},  // R4
    '{1'b1, 12'hD45, 12'h000, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0, 1'b1, 2'd0, 1'b0, 4'd5},  // R5
    '{1'b0, 12'hD45, 12'h000, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd6},  // R6
    '{1'b1, 12'hD45, 12'h000, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd6},  // R6
    '{1'b1, 12'h608, 12'h000, 12'h110, 4'h1, 11'h000, 1'b0, 4'h8, 1'b1, 2'd0, 1'b0, 4'd4},  // R4
    '{1'b1, 12'h608, 12'h000, 12'h110, 4'h1, 11'h002, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd6},  // R6
    '{1'b1, 12'h608, 12'h000, 12'h110, 4'h1, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd6},  // R6
    '{1'b1, 12'h608, 12'h000, 12'h110, 4'h1, 11'h000, 1'b1, 4'h0, 1'b1, 2'd0, 1'b0, 4'd4},  // R4
    '{1'b0, 12'h000, 12'h000, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd2},  // R2
    '{1'b1, 12'h1B0, 12'h000, 12'h000, 4'h1, 11'h7FF, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd11}, // R11
    '{1'b1, 12'h1A0, 12'h000, 12'h000, 4'h1, 11'h400, 1'b0, 4'h0, 1'b1, 2'd0, 1'b0, 4'd11}, // R11
    '{1'b0, 12'h000, 12'h000, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd2},  // R2
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd7},  // R7
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'h1, 11'h000, 1'b1, 4'h0, 1'b1, 2'd0, 1'b0, 4'd7},  // R7
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd7},  // R7
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'hD, 11'h000, 1'b1, 4'h0, 1'b1, 2'd0, 1'b1, 4'd8},  // R8
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'hD, 11'h000, 1'b1, 4'h0, 1'b1, 2'd2, 1'b1, 4'd10}, // R10
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'hD, 11'h000, 1'b0, 4'h0, 1'b1, 2'd3, 1'b0, 4'd9},  // R9
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'hD, 11'h000, 1'b1, 4'h0, 1'b1, 2'd0, 1'b1, 4'd10}, // R10
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'hD, 11'h000, 1'b0, 4'h0, 1'b1, 2'd2, 1'b1, 4'd8},  // R8
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'hD, 11'h000, 1'b0, 4'h0, 1'b1, 2'd3, 1'b0, 4'd9},  // R9
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'hD, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd7},  // R7
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'h6, 11'h000, 1'b1, 4'h0, 1'b1, 2'd1, 1'b1, 4'd8},  // R8
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'h6, 11'h000, 1'b0, 4'h0, 1'b1, 2'd2, 1'b0, 4'd9},  // R9
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'hD, 11'h000, 1'b1, 4'h0, 1'b1, 2'd0, 1'b1, 4'd8},  // R8
    '{1'b0, 12'h000, 12'h200, 12'h000, 4'hD, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd2},  // R2
    '{1'b1, 12'h000, 12'h200, 12'h000, 4'hD, 11'h000, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 4'd2}   // R2
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic traceEn = 1'b0;
  logic [SEL_W-1:0] trigSel = '0, qualSel = '0, stopSel = '0;
  logic [REC_N-1:0] recSel = '0;
  logic [WP_N-1:0] watchpoint = '0;
  logic breakpoint = 1'b0;
  logic [LS_N-1:0] lsStatus = '0;
  logic wrEn, stallReq;
  logic [TAG_W-1:0] wrType;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trace_gate dut (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .trigSel(trigSel),
    .qualSel(qualSel), .stopSel(stopSel), .recSel(recSel),
    .watchpoint(watchpoint), .breakpoint(breakpoint), .lsStatus(lsStatus),
    .wrEn(wrEn), .wrType(wrType), .stallReq(stallReq)
  );

  task automatic checkOut(input string req, input logic xWr, input logic [1:0] xType,
                          input logic xStall);
    nRun++;
    if (wrEn !== xWr || stallReq !== xStall || (xWr && wrType !== xType)) begin
      nFail++;
      $display("FAIL %s: wr=%0b type=%0d stall=%0b, expected wr=%0b type=%0d stall=%0b",
               req, wrEn, wrType, stallReq, xWr, xType, xStall);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    traceEn = v.en; trigSel = v.trig; qualSel = v.qual; stopSel = v.stop;
    recSel = v.rec; watchpoint = v.wp; breakpoint = v.bp; lsStatus = v.ls;
    #1;
  endtask

  initial begin
    // R1: outputs silent while reset is held, even with an always-met setup
    drive('{1'b1, 12'h000, 12'h000, 12'h000, 4'h1, 11'h000, 1'b0, 4'h0,
            1'b0, 2'd0, 1'b0, 4'd1});
    checkOut("R1 in reset", 1'b0, 2'd0, 1'b0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      checkOut($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].xWr, VECS[i].xType,
               VECS[i].xStall);
    end

    // R1: reset in the middle of a sequence drops the remaining samples
    drive('{1'b1, 12'h000, 12'h200, 12'h000, 4'hF, 11'h000, 1'b1, 4'h0,
            1'b0, 2'd0, 1'b0, 4'd1});
    checkOut("R8 seq start", 1'b1, 2'd0, 1'b1);
    rstN = 1'b0;
    #0.5;
    checkOut("R1 reset mid-seq", 1'b0, 2'd0, 1'b0);
    @(negedge clk); rstN = 1'b1;
    breakpoint = 1'b0;
    #1;
    checkOut("R1 seq cleared", 1'b0, 2'd0, 1'b0);

    // R1: reset clears a held trigger
    drive('{1'b1, 12'h1A0, 12'h000, 12'h000, 4'h1, 11'h400, 1'b0, 4'h0,
            1'b0, 2'd0, 1'b0, 4'd1});
    checkOut("R5 trig fire", 1'b1, 2'd0, 1'b0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; watchpoint = '0;
    #1;
    checkOut("R1 trig cleared", 1'b0, 2'd0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule